// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines and raises one interrupt line to a processor. Each line is edge-sensitive: a rising edge sets a bit in the pending register. A pending request is eligible when its mask bit is clear. The lowest-numbered eligible request wins. It raises the processor interrupt only if it outranks every input that is already in service. This means a service routine can be nested by a more urgent source, but never by an equal or lower one.

The processor answers with two acknowledge pulses. On the first pulse, the block moves the winning request from the pending register into the in-service register. During the second pulse, it drives an 8-bit vector onto the data bus. The vector is a programmed 5-bit base followed by the 3-bit index of the winner. A small register port, selected by a chip select, provides the following:
- the mask write;
- the vector base write;
- a command write that carries the non-specific end-of-interrupt and the status-read selector;
- reads of the pending, in-service, mask and base registers.

The data bus is driven only when its enable output is high.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A rising edge on irq_i[n] sets pending bit n. The bit stays set until the acknowledge sequence takes it. An input held high after its bit is taken does not set the bit again until it falls and rises once more.
- R2: Mask bit n = 1 keeps input n out of int_o and out of the selection. Its pending bit is still recorded. The mask resets to all zeros, which enables every input.
- R3: int_o is high exactly when the highest-priority pending unmasked input has a lower index than every set in-service bit. If no in-service bit is set, int_o is high whenever any pending unmasked input exists.
- R4: Among several eligible requests, the lowest index is selected.
- R5: On the first acknowledge pulse (rising edge of inta_i from idle), the selected input's pending bit is cleared and its in-service bit is set.
- R6: While inta_i is high during the second pulse, rdata_oe_o = 1 and rdata_o = {base[4:0], idx[2:0]}. If no request qualified under R3 at the first pulse, idx is 7 and the in-service register is unchanged. rdata_oe_o is 0 during the first pulse.
- R7: Register map for writes with cs_i=1 and wr_i=1:
  - addr 0 is the command. Bit 7 = 1 requests end-of-interrupt. Bit 0 selects the status read: 0 = pending, 1 = in-service.
  - addr 1 is the mask.
  - addr 2 sets base from wdata_i[7:3].
- R8: Reads with cs_i=1 and rd_i=1 drive rdata_oe_o = 1 in the same cycle:
  - addr 1 returns the mask.
  - addr 2 returns {base, 3'b000}.
  - addr 0 and addr 3 return the status register selected by R7.
  - When neither a read nor a second pulse is active, rdata_oe_o = 0.
- R9: An end-of-interrupt command clears only the lowest-indexed set in-service bit.
- R10: After reset the following hold:
  - int_o = 0 and rdata_oe_o = 0.
  - The pending, in-service and mask registers and the base are zero.
  - The status select points at the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request lines, index 0 most urgent |
| inta_i | input | 1 | Acknowledge pulses from the processor, active high |
| cs_i | input | 1 | Register port select |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data or vector |
| rdata_oe_o | output | 1 | Data bus drive enable |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach is nesting. It needs several in-service bits set at once, with a pending request that sits between them in priority. That only happens when an acknowledge arrives, new edges of higher priority follow, and a second acknowledge comes before any end-of-interrupt. The random stimulus mixes edge toggles, mask changes, acknowledge sequences and end-of-interrupt commands with skewed frequencies. The result is that in-service bits pile up and spurious acknowledges, which find no qualifying request, also occur. Directed cases cover a simultaneous arrival, a masked input and an input held high across its acknowledge.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE,
    ACK_P1,
    ACK_GAP,
    ACK_P2
  } ack_state_e;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_BASE = 2'd2;
  localparam int         CMD_EOI_BIT = 7;
  localparam int         CMD_SEL_BIT = 0;
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins: scan downward, last hit kept
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_ack_seq.sv
module pic_ack_seq
  import pic_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inta_i,
  output logic first_o,
  output logic drive_o
);
  ack_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ACK_IDLE: if (inta_i)  state_d = ACK_P1;
      ACK_P1:   if (!inta_i) state_d = ACK_GAP;
      ACK_GAP:  if (inta_i)  state_d = ACK_P2;
      ACK_P2:   if (!inta_i) state_d = ACK_IDLE;
      default:               state_d = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ACK_IDLE;
    else         state_q <= state_d;
  end

  assign first_o = (state_q == ACK_IDLE) && inta_i;
  assign drive_o = inta_i && ((state_q == ACK_GAP) || (state_q == ACK_P2));

  // R6
  p2_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ACK_P2) && (state_d == ACK_P2) |-> state_q == ACK_GAP);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             inta_i,
  input  logic             cs_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rdata_oe_o,
  output logic             int_o
);
  localparam int IW = $clog2(N_IRQ);
  localparam int BW = DW - IW;
  localparam logic [IW-1:0] SPUR_IDX = IW'(N_IRQ - 1);

  logic [N_IRQ-1:0] irq_q, irr_q, isr_q, mask_q, rise;
  logic [BW-1:0]    base_q;
  logic             rsel_q;
  logic [IW-1:0]    vec_idx_q;

  logic          pend_v, isr_v, grant, first_act, ack_drive;
  logic [IW-1:0] pend_idx, isr_idx;
  logic          wr_en, rd_en, eoi_wr;
  logic [N_IRQ-1:0] take, eoi_clr;

  assign rise = irq_i & ~irq_q;

  pic_prio_enc #(.N(N_IRQ), .IW(IW)) u_pend_enc (
    .req_i(irr_q & ~mask_q), .valid_o(pend_v), .idx_o(pend_idx));

  pic_prio_enc #(.N(N_IRQ), .IW(IW)) u_isr_enc (
    .req_i(isr_q), .valid_o(isr_v), .idx_o(isr_idx));

  pic_ack_seq u_ack (
    .clk_i(clk_i), .rst_ni(rst_ni), .inta_i(inta_i),
    .first_o(first_act), .drive_o(ack_drive));

  assign grant  = pend_v && (!isr_v || (pend_idx < isr_idx));
  assign int_o  = grant;
  assign wr_en  = cs_i && wr_i;
  assign rd_en  = cs_i && rd_i;
  assign eoi_wr = wr_en && (addr_i == ADDR_CMD) && wdata_i[CMD_EOI_BIT];

  always_comb begin
    take    = '0;
    eoi_clr = '0;
    if (first_act && grant) take[pend_idx] = 1'b1;
    if (eoi_wr && isr_v)    eoi_clr[isr_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q     <= '0;
      irr_q     <= '0;
      isr_q     <= '0;
      mask_q    <= '0;
      base_q    <= '0;
      rsel_q    <= 1'b0;
      vec_idx_q <= '0;
    end else begin
      irq_q <= irq_i;
      irr_q <= (irr_q & ~take) | rise;
      isr_q <= (isr_q & ~eoi_clr) | take;
      if (first_act) vec_idx_q <= grant ? pend_idx : SPUR_IDX;
      if (wr_en) begin
        unique case (addr_i)
          ADDR_CMD:  rsel_q <= wdata_i[CMD_SEL_BIT];
          ADDR_MASK: mask_q <= wdata_i[N_IRQ-1:0];
          ADDR_BASE: base_q <= wdata_i[DW-1:IW];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ack_drive) begin
      rdata_o = {base_q, vec_idx_q};
    end else if (rd_en) begin
      unique case (addr_i)
        ADDR_MASK: rdata_o = DW'(mask_q);
        ADDR_BASE: rdata_o = {base_q, {IW{1'b0}}};
        default:   rdata_o = DW'(rsel_q ? isr_q : irr_q);
      endcase
    end
  end
  assign rdata_oe_o = ack_drive || rd_en;

  // R3
  int_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> |(irr_q & ~mask_q));
  // R5
  take_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_act && grant |=> isr_q[$past(pend_idx)]);
  // R8
  bus_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> rd_en || inta_i);
  // R9
  eoi_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_wr && isr_v && !first_act |=>
      $countones(isr_q) == $countones($past(isr_q)) - 1);
  // R2
  mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_act && grant |-> !mask_q[pend_idx]);
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] irq_i = '0;
  logic       inta_i = 1'b0, cs_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rdata_oe_o, int_o;

  int checks = 0, failures = 0;
  bit done = 0;

  // model state
  logic [7:0] m_irq = '0, m_irr = '0, m_isr = '0, m_mask = '0;
  logic [4:0] m_base = '0;
  logic       m_sel = 1'b0;

  always #2 clk_i = ~clk_i;

  prio_irq_ctrl dut (.*);

  function automatic int first_set(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit exp_int();
    int p = first_set(m_irr & ~m_mask);
    int s = first_set(m_isr);
    return (p < 8) && (p < s);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_irq(logic [7:0] v);
    @(negedge clk_i);
    irq_i = v;
    m_irr = m_irr | (v & ~m_irq);
    m_irq = v;
    @(posedge clk_i); #1;
  endtask

  task automatic reg_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    case (a)
      2'd0: begin
        m_sel = d[0];
        if (d[7] && first_set(m_isr) < 8) m_isr[first_set(m_isr)] = 1'b0;
      end
      2'd1: m_mask = d;
      2'd2: m_base = d[7:3];
      default: ;
    endcase
    @(negedge clk_i);
    cs_i = 0; wr_i = 0;
  endtask

  task automatic reg_rd(logic [1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk_i);
    cs_i = 1; rd_i = 1; addr_i = a;
    #1; d = rdata_o; oe = rdata_oe_o;
    @(negedge clk_i);
    cs_i = 0; rd_i = 0;
  endtask

  task automatic check_status(string req);
    logic [7:0] d; logic oe;
    reg_wr(2'd0, 8'h00);
    reg_rd(2'd0, d, oe);
    check({req, " pending"}, d, m_irr);
    reg_wr(2'd0, 8'h01);
    reg_rd(2'd0, d, oe);
    check({req, " in-service"}, d, m_isr);
    check({req, " oe"}, oe, 1'b1);
  endtask

  task automatic ack_seq(string req);
    int p = first_set(m_irr & ~m_mask);
    logic [2:0] idx;
    @(negedge clk_i);
    inta_i = 1; #1;
    check({req, " oe first pulse"}, rdata_oe_o, 1'b0);
    if (exp_int()) begin
      idx = 3'(p);
      m_isr[p] = 1'b1;
      m_irr[p] = 1'b0;
    end else idx = 3'd7;
    @(negedge clk_i); inta_i = 0;
    @(negedge clk_i); inta_i = 1; #1;
    check({req, " vector"}, rdata_o, {m_base, idx});
    check({req, " oe second"}, rdata_oe_o, 1'b1);
    @(negedge clk_i); inta_i = 0;
    @(negedge clk_i); #1;
    check({req, " oe idle"}, rdata_oe_o, 1'b0);
  endtask

  task automatic check_int(string req);
    @(negedge clk_i); #1;
    check(req, int_o, exp_int());
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic oe;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    #1; rst_ni = 1;
    // R10 reset state
    #1;
    check("R10 int", int_o, 1'b0);
    check("R10 oe", rdata_oe_o, 1'b0);
    reg_rd(2'd0, d, oe); check("R10 pending", d, 8'h00);
    reg_rd(2'd1, d, oe); check("R10 mask", d, 8'h00);
    reg_rd(2'd2, d, oe); check("R10 base", d, 8'h00);

    reg_wr(2'd2, 8'hA8);
    reg_rd(2'd2, d, oe); check("R7 base", d, 8'hA8);
    // R4 simultaneous arrival
    set_irq(8'h24);
    check_int("R1 int after edges");
    ack_seq("R4 pick 2");
    check_status("R5 after ack");
    // R3 nesting: 0 outranks isr 2, 5 does not
    set_irq(8'h25);
    check_int("R3 higher nests");
    ack_seq("R6 nested vector 0");
    check_int("R3 5 blocked");
    ack_seq("R6 spurious");
    check_status("R6 spurious isr unchanged");
    // R9 EOI clears 0 only
    reg_wr(2'd0, 8'h80);
    check_status("R9 eoi");
    // R1 held-high input not re-pended
    check_int("R1 held");
    // R2 mask
    set_irq(8'h00);
    reg_wr(2'd0, 8'h80);
    reg_wr(2'd1, 8'h08);
    set_irq(8'h08);
    check_int("R2 masked no int");
    check_status("R2 masked recorded");
    reg_rd(2'd1, d, oe); check("R8 mask read", d, 8'h08);
    @(negedge clk_i); #1; check("R8 oe idle", rdata_oe_o, 1'b0);

    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 10;
      if (op < 3)      set_irq(8'($urandom));
      else if (op < 4) reg_wr(2'd1, 8'($urandom & $urandom));
      else if (op < 7) ack_seq("R6 random ack");
      else if (op < 8) reg_wr(2'd0, 8'h80);
      else if (op < 9) reg_wr(2'd2, 8'($urandom));
      else             check_status("R7 random status");
      check_int("R3 random int");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule